// File: doc/BRIEF.md
# Fixed-Latency SDRAM Access Controller

This block connects one host to a single-data-rate SDRAM. Every operation is a single 16-bit read, a single 16-bit write or a refresh. Each operation takes one fixed slot of seven clock cycles, whatever state the banks and rows are in. Inside a slot the controller opens the row, does the column access with auto-precharge, and lets the row close before the slot ends. The same bank can therefore be opened again in the next slot, and the active-to-active spacing of about 65 ns at 100 MHz is still met. Refresh is never started inside the block. The host decides when to refresh and must issue at least 8192 refreshes every 64 ms. A refresh fills the same seven-cycle slot as an access, so host timing stays fully predictable.

Every register in the block updates on the falling clock edge. Commands, address, data and the drive enable of the data bus therefore change half a period before the rising edge at which the SDRAM samples them. This gives even setup and hold margin. The host sees the same timing. It drives `host_req` and its fields from its rising-edge logic, and the block samples them half a period later. `host_done`, `host_ready` and `host_rdata` also change on the falling edge, so the host picks them up at its next rising edge.

After reset the block waits `INIT_WAIT` cycles with NOP commands. It then runs its power-up sequence: precharge all banks, two auto refreshes, and the mode register load for burst length 1, sequential order and CAS latency 2. After that it raises `host_ready`.

Top module: `sdram_slot_ctrl`

## Requirements
- R1: While reset is asserted, `sd_cke` is low and the command is NOP. The command is {cs_n,ras_n,cas_n,we_n} = 0111. `sd_dqm` is all ones, and `host_ready`, `host_done` and `host_rdata` are zero. From the first falling edge after reset, `sd_cke` is high. Until the power-up sequence starts, only NOPs are issued.
- R2: Falling edges are counted from reset release, the first edge being 1. At edge INIT_WAIT+1 the block issues PRECHARGE (0010) with address bit 10 set and bank 0. At edges INIT_WAIT+8 and INIT_WAIT+15 it issues AUTO REFRESH (0001). At edge INIT_WAIT+22 it issues LOAD MODE (0000) with bank 0 and address 0x020, which sets CAS latency 2 in bits 6:4, burst length 1 and sequential order. At edge INIT_WAIT+29 `host_ready` rises and `sd_dqm` drops to zero. Both then stay at those values.
- R3: A request sampled while `host_ready` is low starts nothing. The command stays NOP and `host_done` stays low.
- R4: A read request is accepted when `host_req`=1, `host_we`=0 and `host_refresh`=0 are sampled at a falling edge while ready is high and no slot is running. At that edge (slot cycle 0) the block issues ACTIVE (0011) with the requested bank and row. At cycle 2 it issues READ (0101) with the same bank, the column in the low address bits and bit 10 set. It samples the data bus at cycle 5 (CAS latency 2). At cycle 6 it pulses `host_done` and puts the word on `host_rdata`. Every other cycle of the slot is NOP.
- R5: A write request (`host_we`=1, `host_refresh`=0) is accepted under the same conditions. It produces ACTIVE at cycle 0 and WRITE (0100) at cycle 2, using the read's address layout. The latched write word is driven on `sd_dq` in the WRITE cycle only. `host_done` pulses at cycle 6.
- R6: A refresh request (`host_refresh`=1) issues AUTO REFRESH at cycle 0 and NOP in cycles 1 to 6, and pulses `host_done` at cycle 6.
- R7: Every slot lasts exactly 7 cycles. Requests sampled during cycles 1 to 6 of a slot are ignored. A request held high is accepted again at the falling edge that follows cycle 6. `host_done` is high for one cycle only.
- R8: `host_rdata` keeps its value until the next read slot completes. Writes and refreshes leave it unchanged.
- R9: The block drives `sd_dq` only in the WRITE command cycle. In every other cycle, including the cycle in which read data returns, the bus is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM; all block registers use its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Request strobe, sampled at the falling edge |
| host_we | input | 1 | 1 = write, 0 = read (ignored for refresh) |
| host_refresh | input | 1 | 1 = refresh slot instead of an access |
| host_bank | input | BANK_W | Bank of the access |
| host_row | input | ROW_W | Row of the access |
| host_col | input | COL_W | Column of the access |
| host_wdata | input | DATA_W | Word to write |
| host_rdata | output | DATA_W | Word returned by the most recent read |
| host_done | output | 1 | One-cycle pulse at the end of every slot |
| host_ready | output | 1 | High once power-up initialisation has finished |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed row/column/mode address |
| sd_dqm | output | DATA_W/8 | Byte data masks |
| sd_dq | inout | DATA_W | Bidirectional data bus |

## Verification
The bench first sends requests during power-up, to show that they are dropped before ready. It then holds the request line high through a chain of back-to-back writes, reads and refreshes. This separates correct acceptance at the eighth falling edge from acceptance that comes one cycle early or late. Reads go to a bank whose row differs from the last write. They also go to a second column of the same row and to a location never written. Wrong address multiplexing, a wrong capture cycle and stale data all give different read values. A refresh and a write placed between two reads show whether the returned word is held or overwritten.

// File: rtl/sdram_slot_pkg.sv
package sdram_slot_pkg;

    // SDRAM command encoding {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    // Slot timing, in clock cycles
    localparam int SLOT_CYC  = 7;
    localparam int TRCD_CYC  = 2;
    localparam int CAS_LAT   = 2;
    localparam int INIT_GAP  = 7;
    localparam int STEP_W    = $clog2(SLOT_CYC);
    localparam int CAP_STEP  = TRCD_CYC + CAS_LAT + 1;
    localparam int DONE_STEP = SLOT_CYC - 1;
    localparam int AP_BIT    = 10;

endpackage

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdram_slot_pkg::*;
#(
    parameter int INIT_WAIT = 10000
) (
    input  logic    clk,
    input  logic    rst_n,
    output sd_cmd_e cmd_o,
    output logic    done_o
);

    localparam int LAST = INIT_WAIT + 4 * INIT_GAP;
    localparam int CW   = $clog2(LAST + 1);

    localparam logic [CW-1:0] T_PRE  = CW'(INIT_WAIT);
    localparam logic [CW-1:0] T_REF0 = CW'(INIT_WAIT + INIT_GAP);
    localparam logic [CW-1:0] T_REF1 = CW'(INIT_WAIT + 2 * INIT_GAP);
    localparam logic [CW-1:0] T_LMR  = CW'(INIT_WAIT + 3 * INIT_GAP);
    localparam logic [CW-1:0] T_END  = CW'(LAST);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != T_END) begin
            cnt_d = cnt_q + CW'(1);
        end
        cmd_o = CMD_NOP;
        if (cnt_q == T_PRE) begin
            cmd_o = CMD_PRE;
        end else if (cnt_q == T_REF0 || cnt_q == T_REF1) begin
            cmd_o = CMD_REF;
        end else if (cnt_q == T_LMR) begin
            cmd_o = CMD_LMR;
        end
        done_o = (cnt_q == T_END);
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sdram_slot_seq.sv
module sdram_slot_seq
    import sdram_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic [STEP_W-1:0] step_o
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SLOT_CYC - 1);

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.step == LAST_STEP) begin
                s_d.busy = 1'b0;
                s_d.step = '0;
            end else begin
                s_d.step = s_q.step + STEP_W'(1);
            end
        end else if (start_i) begin
            s_d.busy = 1'b1;
            s_d.step = STEP_W'(1);
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
    assign step_o = s_q.step;

endmodule

// File: rtl/sdram_slot_ctrl.sv
module sdram_slot_ctrl
    import sdram_slot_pkg::*;
#(
    parameter int INIT_WAIT = 10000,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_refresh,
    input  logic [BANK_W-1:0] host_bank,
    input  logic [ROW_W-1:0]  host_row,
    input  logic [COL_W-1:0]  host_col,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic              host_ready,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DATA_W/8-1:0] sd_dqm,
    inout  wire  [DATA_W-1:0] sd_dq
);

    localparam int DM_W = DATA_W / 8;

    // Address bit 10 selects all banks / auto-precharge; the column sits below it
    localparam logic [ROW_W-1:0] PRE_ALL_WORD = ROW_W'(1 << AP_BIT);
    // Mode: burst length 1 (000), sequential (bit 3 = 0), CAS latency in bits 6:4
    localparam logic [ROW_W-1:0] MODE_WORD    = ROW_W'(CAS_LAT << 4);

    localparam logic [STEP_W-1:0] ST_COL  = STEP_W'(TRCD_CYC);
    localparam logic [STEP_W-1:0] ST_CAP  = STEP_W'(CAP_STEP);
    localparam logic [STEP_W-1:0] ST_DONE = STEP_W'(DONE_STEP);

    typedef struct packed {
        logic              cke;
        logic              ready;
        sd_cmd_e           cmd;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  addr;
        logic [DM_W-1:0]   dqm;
        logic              oe;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rtmp;
        logic [DATA_W-1:0] rd;
        logic              done;
        logic              is_ref;
        logic              is_wr;
        logic [BANK_W-1:0] bank_l;
        logic [COL_W-1:0]  col_l;
    } ctrl_t;

    ctrl_t r_d, r_q;

    sd_cmd_e           init_cmd;
    logic              init_done;
    logic              slot_busy;
    logic [STEP_W-1:0] slot_step;
    logic              slot_start;
    logic [ROW_W-1:0]  col_word;

    sdram_powerup_seq #(
        .INIT_WAIT (INIT_WAIT)
    ) u_powerup (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_o  (init_cmd),
        .done_o (init_done)
    );

    assign slot_start = r_q.ready && !slot_busy && host_req;

    sdram_slot_seq u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (slot_start),
        .busy_o  (slot_busy),
        .step_o  (slot_step)
    );

    always_comb begin
        col_word              = '0;
        col_word[COL_W-1:0]   = r_q.col_l;
        col_word[AP_BIT]      = 1'b1;
    end

    always_comb begin
        r_d       = r_q;
        r_d.cke   = 1'b1;
        r_d.cmd   = CMD_NOP;
        r_d.oe    = 1'b0;
        r_d.done  = 1'b0;
        r_d.ready = init_done;
        r_d.dqm   = init_done ? '0 : '1;

        if (!r_q.ready) begin
            // power-up sequence owns the command bus
            r_d.cmd = init_cmd;
            if (init_cmd == CMD_PRE) begin
                r_d.ba   = '0;
                r_d.addr = PRE_ALL_WORD;
            end else if (init_cmd == CMD_LMR) begin
                r_d.ba   = '0;
                r_d.addr = MODE_WORD;
            end
        end else if (slot_start) begin
            r_d.is_ref = host_refresh;
            r_d.is_wr  = host_we;
            r_d.bank_l = host_bank;
            r_d.col_l  = host_col;
            r_d.wd     = host_wdata;
            if (host_refresh) begin
                r_d.cmd = CMD_REF;
            end else begin
                r_d.cmd  = CMD_ACT;
                r_d.ba   = host_bank;
                r_d.addr = host_row;
            end
        end else if (slot_busy) begin
            if (slot_step == ST_COL && !r_q.is_ref) begin
                r_d.cmd  = r_q.is_wr ? CMD_WR : CMD_RD;
                r_d.ba   = r_q.bank_l;
                r_d.addr = col_word;
                r_d.oe   = r_q.is_wr;
            end
            if (slot_step == ST_CAP && !r_q.is_ref && !r_q.is_wr) begin
                r_d.rtmp = sd_dq;
            end
            if (slot_step == ST_DONE) begin
                r_d.done = 1'b1;
                if (!r_q.is_ref && !r_q.is_wr) begin
                    r_d.rd = r_q.rtmp;
                end
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.cmd <= CMD_NOP;
            r_q.dqm <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sd_dq      = r_q.oe ? r_q.wd : 'z;
    assign host_rdata = r_q.rd;
    assign host_done  = r_q.done;
    assign host_ready = r_q.ready;
    assign sd_cke     = r_q.cke;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = r_q.cmd;
    assign sd_ba      = r_q.ba;
    assign sd_addr    = r_q.addr;
    assign sd_dqm     = r_q.dqm;

    // observation points for the bound checker
    logic [3:0] chk_cmd;
    logic       chk_oe;
    assign chk_cmd = r_q.cmd;
    assign chk_oe  = r_q.oe;

endmodule

// File: rtl/sdram_slot_chk.sv
module sdram_slot_chk
    import sdram_slot_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cmd,
    input logic       ready,
    input logic       done,
    input logic       oe,
    input logic       cke
);

    // R2
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R3
    no_access_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !(cmd == CMD_ACT || cmd == CMD_RD || cmd == CMD_WR));

    // R4
    col_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> $past(cmd, 2) == CMD_ACT);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cmd, 6) == CMD_ACT || $past(cmd, 6) == CMD_REF));

    // R9
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> cmd == CMD_WR);

    // R1
    cke_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cke);

endmodule

bind sdram_slot_ctrl sdram_slot_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (chk_cmd),
    .ready (host_ready),
    .done  (host_done),
    .oe    (chk_oe),
    .cke   (sd_cke)
);

// File: tb/tb_sdram_slot_ctrl.sv
module tb_sdram_slot_ctrl;

    localparam int W = 40;

    localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                           C_NOP = 4'b0111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, host_refresh = 1'b0;
    logic [1:0]  host_bank = '0;
    logic [12:0] host_row = '0;
    logic [8:0]  host_col = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_done, host_ready;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [1:0]  sd_dqm;
    wire  [15:0] sd_dq;

    logic        mdl_oe = 1'b0;
    logic [15:0] mdl_dq = '0;
    assign sd_dq = mdl_oe ? mdl_dq : 'z;

    always #10 clk = ~clk;

    sdram_slot_ctrl #(.INIT_WAIT(W)) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_refresh(host_refresh), .host_bank(host_bank), .host_row(host_row),
        .host_col(host_col), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_done(host_done), .host_ready(host_ready), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .sd_dq(sd_dq)
    );

    typedef struct {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
        bit          chk_addr;
        bit          wr;
        logic [15:0] wd;
        bit          done;
        bit          rd_upd;
        logic [15:0] rd_val;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] shadow[int];
    logic [15:0] mem[int];
    logic [12:0] open_row[4];
    logic [15:0] rd_word = '0;
    int          rd_cnt = 0;
    int          t = 0;
    int          n_chk = 0, n_fail = 0;
    bit          ready_m = 0;
    logic [15:0] last_rd = '0;
    string       ign_tag = "";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic exp_t blank(input string tg);
        exp_t e;
        e.cmd = C_NOP; e.ba = '0; e.addr = '0; e.chk_addr = 0; e.wr = 0;
        e.wd = '0; e.done = 0; e.rd_upd = 0; e.rd_val = '0; e.tag = tg;
        return e;
    endfunction

    task automatic push_slot(input bit we, input bit rf, input logic [1:0] b,
                             input logic [12:0] r, input logic [8:0] c,
                             input logic [15:0] d);
        exp_t  e;
        string tg;
        int    key;
        key = int'({b, r, c});
        tg  = rf ? "R6" : (we ? "R5" : "R4");
        for (int k = 0; k < 7; k++) begin
            e = blank(tg);
            if (k == 0) begin
                e.cmd = rf ? C_REF : C_ACT;
                if (!rf) begin e.chk_addr = 1; e.ba = b; e.addr = r; end
            end
            if (k == 2 && !rf) begin
                e.cmd = we ? C_WR : C_RD;
                e.chk_addr = 1; e.ba = b; e.addr = 13'h400 | {4'b0, c};
                e.wr = we; e.wd = d;
            end
            if (k == 6) begin
                e.done = 1;
                if (!rf && !we) begin
                    e.rd_upd = 1;
                    e.rd_val = shadow.exists(key) ? shadow[key] : 16'h0000;
                    e.tag = "R4 R9";
                end
            end
            q.push_back(e);
        end
        if (we && !rf) shadow[key] = d;
    endtask

    task automatic observe();
        exp_t        e;
        string       tg;
        logic [3:0]  cmd;
        int          key;
        t++;
        if (q.size() > 0) e = q.pop_front();
        else e = blank((t <= W + 29) ? "R1" : "R7");
        if (t == W + 1)  begin e = blank("R2"); e.cmd = C_PRE; e.chk_addr = 1; e.addr = 13'h400; end
        if (t == W + 8 || t == W + 15) begin e = blank("R2"); e.cmd = C_REF; end
        if (t == W + 22) begin e = blank("R2"); e.cmd = C_LMR; e.chk_addr = 1; e.addr = 13'h020; end
        ready_m = (t >= W + 29);
        if (e.rd_upd) last_rd = e.rd_val;
        tg = e.tag;
        if (ign_tag != "") begin tg = ign_tag; ign_tag = ""; end
        cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

        chk(cmd == e.cmd, tg, "command", {28'h0, cmd}, {28'h0, e.cmd});
        chk(host_ready == ready_m, "R2", "ready", {31'h0, host_ready}, {31'h0, ready_m});
        chk(host_done == e.done, tg, "done", {31'h0, host_done}, {31'h0, e.done});
        chk(sd_cke == 1'b1, "R1", "cke", {31'h0, sd_cke}, 32'h1);
        chk(sd_dqm == (ready_m ? 2'b00 : 2'b11), "R2", "dqm", {30'h0, sd_dqm},
            ready_m ? 32'h0 : 32'h3);
        if (e.chk_addr) begin
            chk(sd_ba == e.ba, tg, "bank", {30'h0, sd_ba}, {30'h0, e.ba});
            chk(sd_addr == e.addr, tg, "address", {19'h0, sd_addr}, {19'h0, e.addr});
        end
        if (e.wr) chk(sd_dq === e.wd, "R5", "write data", {16'h0, sd_dq}, {16'h0, e.wd});
        chk(host_rdata == last_rd, e.rd_upd ? tg : "R8", "read data",
            {16'h0, host_rdata}, {16'h0, last_rd});

        // SDRAM behaviour as seen at the rising edge just passed
        if (mdl_oe) mdl_oe = 1'b0;
        if (rd_cnt == 1) begin mdl_oe = 1'b1; mdl_dq = rd_word; end
        if (rd_cnt > 0) rd_cnt--;
        if (cmd == C_ACT) open_row[sd_ba] = sd_addr;
        if (cmd == C_WR || cmd == C_RD) begin
            key = int'({sd_ba, open_row[sd_ba], sd_addr[8:0]});
            if (cmd == C_WR) mem[key] = sd_dq;
            else begin
                rd_word = mem.exists(key) ? mem[key] : 16'h0000;
                rd_cnt = 2;
            end
        end
    endtask

    task automatic tick(input bit rq, input bit we, input bit rf, input logic [1:0] b,
                        input logic [12:0] r, input logic [8:0] c, input logic [15:0] d,
                        output bit taken);
        @(posedge clk);
        #1;
        observe();
        host_req = rq; host_we = we; host_refresh = rf;
        host_bank = b; host_row = r; host_col = c; host_wdata = d;
        taken = 0;
        if (rq) begin
            if (ready_m && q.size() == 0) begin
                push_slot(we, rf, b, r, c, d);
                taken = 1;
            end else begin
                ign_tag = ready_m ? "R7" : "R3";
            end
        end
    endtask

    task automatic do_op(input bit we, input bit rf, input logic [1:0] b,
                         input logic [12:0] r, input logic [8:0] c, input logic [15:0] d);
        bit tk;
        tk = 0;
        while (!tk) tick(1'b1, we, rf, b, r, c, d, tk);
    endtask

    task automatic idle(input int n);
        bit tk;
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, '0, '0, '0, '0, tk);
    endtask

    initial begin
        bit tk;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(sd_cke == 1'b0, "R1", "cke in reset", {31'h0, sd_cke}, 32'h0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "command in reset",
            {28'h0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'h0, C_NOP});
        chk(host_ready == 1'b0, "R1", "ready in reset", {31'h0, host_ready}, 32'h0);
        chk(host_done == 1'b0, "R1", "done in reset", {31'h0, host_done}, 32'h0);
        chk(sd_dqm == 2'b11, "R1", "dqm in reset", {30'h0, sd_dqm}, 32'h3);
        chk(host_rdata == 16'h0, "R1", "rdata in reset", {16'h0, host_rdata}, 32'h0);
        rst_n = 1'b1;

        // R3 requests during power-up are dropped
        idle(4);
        tick(1'b1, 1'b1, 1'b0, 2'd1, 13'h0AA, 9'h011, 16'hDEAD, tk);
        tick(1'b0, 1'b0, 1'b0, '0, '0, '0, '0, tk);
        idle(W + 10);
        tick(1'b1, 1'b0, 1'b0, 2'd1, 13'h0AA, 9'h011, 16'h0, tk);
        tick(1'b1, 1'b0, 1'b1, 2'd0, 13'h0, 9'h0, 16'h0, tk);
        while (!ready_m) tick(1'b0, 1'b0, 1'b0, '0, '0, '0, '0, tk);

        // back-to-back slots with request held high (R4, R5, R6, R7, R8)
        do_op(1'b1, 1'b0, 2'd1, 13'h123, 9'h005, 16'hA5A5);
        do_op(1'b1, 1'b0, 2'd2, 13'h1FFF, 9'h1FF, 16'h3C3C);
        do_op(1'b0, 1'b0, 2'd1, 13'h123, 9'h005, 16'h0);
        do_op(1'b0, 1'b1, 2'd0, 13'h0, 9'h0, 16'h0);
        do_op(1'b1, 1'b0, 2'd1, 13'h123, 9'h006, 16'h5AF0);
        idle(9);
        do_op(1'b0, 1'b0, 2'd2, 13'h1FFF, 9'h1FF, 16'h0);
        do_op(1'b0, 1'b0, 2'd1, 13'h123, 9'h006, 16'h0);
        do_op(1'b0, 1'b0, 2'd3, 13'h0777, 9'h044, 16'h0);
        do_op(1'b1, 1'b0, 2'd3, 13'h0777, 9'h044, 16'hFFFF);
        do_op(1'b0, 1'b1, 2'd0, 13'h0, 9'h0, 16'h0);
        do_op(1'b0, 1'b0, 2'd3, 13'h0777, 9'h044, 16'h0);
        do_op(1'b0, 1'b0, 2'd1, 13'h123, 9'h005, 16'h0);
        idle(12);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule